// File: doc/BRIEF.md
# Glitch-Free Clock Stop Controller

This block gates three clock groups of a system clock generator under control of asynchronous, active-low power-management requests. The CPU group runs on the CPU clock; the stoppable PCI group and the free group (the free-running PCI clock and the AGP clocks) run on the PCI clock. A mode pin selects whether the requests are honoured: with mode low, three pins that otherwise carry memory clock outputs act as the power-down, CPU-stop and PCI-stop inputs; with mode high every request is treated as inactive.

Each request is brought into the domain of the clock it gates through its own synchronizer, and every enable is registered on the falling edge of its source clock, so a gated output only starts or stops across a complete low phase and never shows a shortened high pulse. The CPU group takes a two-stage synchronizer, the PCI-clock groups a single stage, which sets the fixed on/off latencies. Shutdown of the oscillator and PLLs is represented by a single indication that rises once power-down has been seen and every group has stopped.

Top module: `clk_stop_ctrl`

## Requirements
- R1: While mode_i is 1, all three enables settle to 1 and osc_off_o to 0 whatever the levels of pwrdn_ni, cpu_stop_ni and pci_stop_ni; after reset all enables are 1 and osc_off_o is 0.
- R2: With mode_i at 0, driving cpu_stop_ni to 0 just after a rising edge of cpu_clk_i lets exactly two more rising edges appear on cpu_clk_o, after which it stays low; driving it back to 1 the same way keeps the next two edges absent and restores cpu_clk_o from the third rising edge on.
- R3: With mode_i at 0, driving pci_stop_ni to 0 just after a rising edge of pci_clk_i lets exactly one more rising edge appear on pci_clk_o, after which it stays low; releasing it the same way keeps the next edge absent and restores pci_clk_o from the second rising edge on.
- R4: free_clk_o and free_en_o are unaffected by cpu_stop_ni and pci_stop_ni.
- R5: With mode_i at 0, pwrdn_ni at 0 stops all three groups: the CPU group with the R2 latency, the PCI and free groups with the R3 latency, and the stop is undone with the same latencies.
- R6: osc_off_o is 1 only while power-down has been seen in the PCI domain and all three enables are 0; in steady state it equals (mode_i == 0 and pwrdn_ni == 0).
- R7: Every high pulse on cpu_clk_o, pci_clk_o and free_clk_o lasts the full high phase of its source clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk_i | input | 1 | CPU group source clock |
| pci_clk_i | input | 1 | PCI and free group source clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | 0: request pins act as power-management inputs |
| pwrdn_ni | input | 1 | Power-down request, active low, asynchronous |
| cpu_stop_ni | input | 1 | CPU group stop request, active low, asynchronous |
| pci_stop_ni | input | 1 | PCI group stop request, active low, asynchronous |
| cpu_en_o | output | 1 | CPU group enable |
| pci_en_o | output | 1 | Stoppable PCI group enable |
| free_en_o | output | 1 | Free group enable |
| cpu_clk_o | output | 1 | Gated CPU clock |
| pci_clk_o | output | 1 | Gated stoppable PCI clock |
| free_clk_o | output | 1 | Gated free-group clock |
| osc_off_o | output | 1 | Oscillator and PLL shutdown indication |

## Verification
A synchronizer stage too many or too few shows at once as one rising edge more or fewer on a gated clock after a request changes, counted edge by edge from the change. An enable registered on the wrong clock edge, or taken from the unsynchronized request, shows as a high pulse shorter than the source half period on the very pulse where the stop lands. A wrong request decode appears within a few PCI cycles as a settled enable or indication that disagrees with the sweep over all mode and request combinations.

// File: rtl/clk_stop_pkg.sv
`timescale 1ns/1ps
package clk_stop_pkg;
  localparam int CPU_SYNC_DEPTH = 2;
  localparam int PCI_SYNC_DEPTH = 1;
  localparam int PCI_GROUPS     = 2;  // index 0: stoppable PCI, 1: free group

  typedef struct packed {
    logic cpu_run;
    logic pci_run;
    logic free_run;
    logic pd_req;
  } stop_req_t;
endpackage

// File: rtl/cs_req_decode.sv
`timescale 1ns/1ps
module cs_req_decode
  import clk_stop_pkg::*;
(
  input  logic      mode_i,
  input  logic      pwrdn_ni,
  input  logic      cpu_stop_ni,
  input  logic      pci_stop_ni,
  output stop_req_t req_o
);
  logic pm_act;

  always_comb begin
    pm_act         = ~mode_i;
    req_o.cpu_run  = ~pm_act | (cpu_stop_ni & pwrdn_ni);
    req_o.pci_run  = ~pm_act | (pci_stop_ni & pwrdn_ni);
    req_o.free_run = ~pm_act | pwrdn_ni;
    req_o.pd_req   = pm_act & ~pwrdn_ni;
  end
endmodule

// File: rtl/cs_sync.sv
`timescale 1ns/1ps
module cs_sync #(
  parameter int   DEPTH   = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  generate
    if (DEPTH <= 1) begin : g_one
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= RST_VAL;
        else         q <= d_i;
      end
      assign q_o = q;
    end else begin : g_chain
      logic [DEPTH-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= {DEPTH{RST_VAL}};
        else         q <= {q[DEPTH-2:0], d_i};
      end
      assign q_o = q[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/cs_gate.sv
`timescale 1ns/1ps
module cs_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic en_o,
  output logic clk_o
);
  // enable moves only while clk_i is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_o <= 1'b1;
    else         en_o <= run_i;
  end

  assign clk_o = clk_i & en_o;
endmodule

// File: rtl/clk_stop_ctrl.sv
`timescale 1ns/1ps
module clk_stop_ctrl
  import clk_stop_pkg::*;
#(
  parameter int CPU_SYNC = CPU_SYNC_DEPTH,
  parameter int PCI_SYNC = PCI_SYNC_DEPTH
) (
  input  logic cpu_clk_i,
  input  logic pci_clk_i,
  input  logic rst_ni,
  input  logic mode_i,
  input  logic pwrdn_ni,
  input  logic cpu_stop_ni,
  input  logic pci_stop_ni,
  output logic cpu_en_o,
  output logic pci_en_o,
  output logic free_en_o,
  output logic cpu_clk_o,
  output logic pci_clk_o,
  output logic free_clk_o,
  output logic osc_off_o
);
  stop_req_t req;

  cs_req_decode u_dec (
    .mode_i      (mode_i),
    .pwrdn_ni    (pwrdn_ni),
    .cpu_stop_ni (cpu_stop_ni),
    .pci_stop_ni (pci_stop_ni),
    .req_o       (req)
  );

  // CPU domain
  logic cpu_run_s;

  cs_sync #(.DEPTH(CPU_SYNC), .RST_VAL(1'b1)) u_cpu_sync (
    .clk_i  (cpu_clk_i),
    .rst_ni (rst_ni),
    .d_i    (req.cpu_run),
    .q_o    (cpu_run_s)
  );

  cs_gate u_cpu_gate (
    .clk_i  (cpu_clk_i),
    .rst_ni (rst_ni),
    .run_i  (cpu_run_s),
    .en_o   (cpu_en_o),
    .clk_o  (cpu_clk_o)
  );

  // PCI domain groups
  logic [PCI_GROUPS-1:0] pci_run_raw, pci_run_s, pci_en, pci_gclk;

  assign pci_run_raw = {req.free_run, req.pci_run};

  for (genvar g = 0; g < PCI_GROUPS; g++) begin : g_pci_grp
    cs_sync #(.DEPTH(PCI_SYNC), .RST_VAL(1'b1)) u_sync (
      .clk_i  (pci_clk_i),
      .rst_ni (rst_ni),
      .d_i    (pci_run_raw[g]),
      .q_o    (pci_run_s[g])
    );
    cs_gate u_gate (
      .clk_i  (pci_clk_i),
      .rst_ni (rst_ni),
      .run_i  (pci_run_s[g]),
      .en_o   (pci_en[g]),
      .clk_o  (pci_gclk[g])
    );
  end

  assign pci_en_o   = pci_en[0];
  assign free_en_o  = pci_en[1];
  assign pci_clk_o  = pci_gclk[0];
  assign free_clk_o = pci_gclk[1];

  // power-down flag, seen in PCI domain
  logic pd_s, pd_seen;

  cs_sync #(.DEPTH(PCI_SYNC), .RST_VAL(1'b0)) u_pd_sync (
    .clk_i  (pci_clk_i),
    .rst_ni (rst_ni),
    .d_i    (req.pd_req),
    .q_o    (pd_s)
  );

  always_ff @(negedge pci_clk_i or negedge rst_ni) begin
    if (!rst_ni) pd_seen <= 1'b0;
    else         pd_seen <= pd_s;
  end

  // flag shutdown only once every group is parked low
  assign osc_off_o = pd_seen & ~cpu_en_o & ~pci_en_o & ~free_en_o;
endmodule

// File: rtl/clk_stop_ctrl_chk.sv
`timescale 1ns/1ps
module clk_stop_ctrl_chk (
  input logic cpu_clk_i,
  input logic pci_clk_i,
  input logic rst_ni,
  input logic mode_i,
  input logic pwrdn_ni,
  input logic cpu_stop_ni,
  input logic pci_stop_ni,
  input logic cpu_en_o,
  input logic pci_en_o,
  input logic free_en_o,
  input logic osc_off_o
);
  AST_MODE_CPU_RUN: assert property (@(posedge cpu_clk_i) disable iff (!rst_ni)
    ($past(mode_i) && $past(mode_i, 2) && $past(mode_i, 3)) |-> cpu_en_o); // R1

  AST_MODE_PCI_RUN: assert property (@(posedge pci_clk_i) disable iff (!rst_ni)
    ($past(mode_i) && $past(mode_i, 2)) |-> (pci_en_o && free_en_o && !osc_off_o)); // R1

  AST_CPU_STOP_HOLD: assert property (@(posedge cpu_clk_i) disable iff (!rst_ni)
    (!$past(mode_i) && !$past(mode_i, 2) && !$past(cpu_stop_ni) && !$past(cpu_stop_ni, 2))
    |-> !cpu_en_o); // R2

  AST_PCI_STOP_HOLD: assert property (@(posedge pci_clk_i) disable iff (!rst_ni)
    (!$past(mode_i) && !$past(pci_stop_ni)) |-> !pci_en_o); // R3

  AST_FREE_IGNORES_STOPS: assert property (@(posedge pci_clk_i) disable iff (!rst_ni)
    (($past(mode_i) || $past(pwrdn_ni)) && ($past(mode_i, 2) || $past(pwrdn_ni, 2)))
    |-> free_en_o); // R4

  AST_PD_STOPS_PCI: assert property (@(posedge pci_clk_i) disable iff (!rst_ni)
    (!$past(mode_i) && !$past(pwrdn_ni)) |-> (!pci_en_o && !free_en_o)); // R5

  AST_OSC_AFTER_STOP: assert property (@(posedge pci_clk_i) disable iff (!rst_ni)
    osc_off_o |-> (!cpu_en_o && !pci_en_o && !free_en_o)); // R6
endmodule

bind clk_stop_ctrl clk_stop_ctrl_chk u_chk (
  .cpu_clk_i   (cpu_clk_i),
  .pci_clk_i   (pci_clk_i),
  .rst_ni      (rst_ni),
  .mode_i      (mode_i),
  .pwrdn_ni    (pwrdn_ni),
  .cpu_stop_ni (cpu_stop_ni),
  .pci_stop_ni (pci_stop_ni),
  .cpu_en_o    (cpu_en_o),
  .pci_en_o    (pci_en_o),
  .free_en_o   (free_en_o),
  .osc_off_o   (osc_off_o)
);

// File: tb/clk_stop_ctrl_test.sv
`timescale 1ns/1ps
module clk_stop_ctrl_test;
  localparam real CPU_HALF = 4.0;   // 125 MHz
  localparam real PCI_HALF = 8.0;

  logic cpu_clk = 1'b0, pci_clk = 1'b0, rst_n = 1'b0;
  logic mode = 1'b1, pd_n = 1'b1, cstop_n = 1'b1, pstop_n = 1'b1;
  logic cpu_en, pci_en, free_en, cpu_g, pci_g, free_g, osc_off;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  clk_stop_ctrl uut (
    .cpu_clk_i (cpu_clk), .pci_clk_i (pci_clk), .rst_ni (rst_n),
    .mode_i (mode), .pwrdn_ni (pd_n), .cpu_stop_ni (cstop_n), .pci_stop_ni (pstop_n),
    .cpu_en_o (cpu_en), .pci_en_o (pci_en), .free_en_o (free_en),
    .cpu_clk_o (cpu_g), .pci_clk_o (pci_g), .free_clk_o (free_g),
    .osc_off_o (osc_off)
  );

  initial forever #(CPU_HALF) cpu_clk = ~cpu_clk;
  initial forever #(PCI_HALF) pci_clk = ~pci_clk;

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // R7: pulse width monitors
  real t_cpu = 0.0, t_pci = 0.0, t_free = 0.0;
  always @(posedge cpu_g)  t_cpu  = $realtime;
  always @(posedge pci_g)  t_pci  = $realtime;
  always @(posedge free_g) t_free = $realtime;

  task automatic chk_width(input string tag, input real w, input real exp);
    checks++;
    if (w < exp - 0.01 || w > exp + 0.01) begin
      errors++;
      $display("FAIL %s: pulse width actual %0.3f expected %0.3f at %0t", tag, w, exp, $time);
    end
  endtask

  always @(negedge cpu_g)  if (!done) chk_width("R7 cpu_clk_o",  $realtime - t_cpu,  CPU_HALF);
  always @(negedge pci_g)  if (!done) chk_width("R7 pci_clk_o",  $realtime - t_pci,  PCI_HALF);
  always @(negedge free_g) if (!done) chk_width("R7 free_clk_o", $realtime - t_free, PCI_HALF);

  task automatic settle();
    repeat (6) @(posedge pci_clk);
    #1;
  endtask

  task automatic run_state();
    mode = 1'b0; pd_n = 1'b1; cstop_n = 1'b1; pstop_n = 1'b1;
    settle();
  endtask

  // CPU group latency; use_pd selects the pin that is toggled
  task automatic cpu_latency(input bit use_pd, input string tag);
    logic exp;
    run_state();
    for (int ph = 0; ph < 2; ph++) begin
      @(posedge cpu_clk); #1;
      if (use_pd) pd_n = logic'(ph); else cstop_n = logic'(ph);
      for (int i = 1; i <= 5; i++) begin
        @(posedge cpu_clk); #1;
        exp = (ph == 0) ? (i <= 2) : (i >= 3);
        chk(tag, cpu_g, exp);
      end
    end
  endtask

  // PCI group latency; free group follows only power-down
  task automatic pci_latency(input bit use_pd, input string tag);
    logic exp;
    run_state();
    for (int ph = 0; ph < 2; ph++) begin
      @(posedge pci_clk); #1;
      if (use_pd) pd_n = logic'(ph); else pstop_n = logic'(ph);
      for (int i = 1; i <= 4; i++) begin
        @(posedge pci_clk); #1;
        exp = (ph == 0) ? (i <= 1) : (i >= 2);
        chk(tag, pci_g, exp);
        if (use_pd) chk("R5 free_clk_o latency", free_g, exp);
        else        chk("R4 free_clk_o during pci stop", free_g, 1'b1);
      end
    end
  endtask

  initial begin
    #(200000 * 2 * CPU_HALF);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge pci_clk);
    #1;
    chk("R1 reset cpu_en_o", cpu_en, 1'b1);
    chk("R1 reset pci_en_o", pci_en, 1'b1);
    chk("R1 reset free_en_o", free_en, 1'b1);
    chk("R1 reset osc_off_o", osc_off, 1'b0);
    rst_n = 1'b1;

    // steady-state sweep over all mode/request combinations
    for (int v = 0; v < 16; v++) begin
      logic act, e_cpu, e_pci, e_free, e_osc;
      mode = logic'(v[3]); pd_n = logic'(v[2]); cstop_n = logic'(v[1]); pstop_n = logic'(v[0]);
      settle();
      act    = ~mode;
      e_cpu  = ~(act & (~cstop_n | ~pd_n));
      e_pci  = ~(act & (~pstop_n | ~pd_n));
      e_free = ~(act & ~pd_n);
      e_osc  = act & ~pd_n;
      chk(mode ? "R1 cpu_en_o sweep" : "R2 cpu_en_o sweep", cpu_en, e_cpu);
      chk(mode ? "R1 pci_en_o sweep" : "R3 pci_en_o sweep", pci_en, e_pci);
      chk(mode ? "R1 free_en_o sweep" : "R4 free_en_o sweep", free_en, e_free);
      chk(mode ? "R1 osc_off_o sweep" : "R6 osc_off_o sweep", osc_off, e_osc);
    end

    cpu_latency(1'b0, "R2 cpu_clk_o stop/start latency");
    pci_latency(1'b0, "R3 pci_clk_o stop/start latency");
    cpu_latency(1'b1, "R5 cpu_clk_o power-down latency");
    pci_latency(1'b1, "R5 pci_clk_o power-down latency");

    // R6: indication tracks power-down and clears on release
    run_state();
    pd_n = 1'b0;
    settle();
    chk("R6 osc_off_o in power-down", osc_off, 1'b1);
    mode = 1'b1;
    settle();
    chk("R6 osc_off_o after mode high", osc_off, 1'b0);
    chk("R1 free_en_o after mode high", free_en, 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule